// File: doc/BRIEF.md
# Machine State Register Update Unit

This unit holds the 32-bit machine state word that sets the processor's operating state. Three operations can rewrite it: a move-to-register write, entry to a system call, and a return from an exception. A fourth event, taking a translation-miss exception (instruction fetch miss, data load miss or data store miss), can only set the temporary register-remap bit. The current word is always visible on `msr_q`, which serves as the move-from-register read port. Two bits are also brought out on their own pins: the power-mode enable and the remap mode.

Bits are numbered most-significant-first, so architectural bit n sits at vector index 31-n. The power-mode enable (architectural bit 13) is at index 18. The remap bit (architectural bit 14) is at index 17. The remap bit is owned by a two-state machine with states RM_NORMAL and RM_REMAP and four named transitions:

- T_MISS_ENTER goes from RM_NORMAL to RM_REMAP when a miss exception is taken.
- T_MOVE_SET goes from RM_NORMAL to RM_REMAP when a move writes 1 to index 17.
- T_RETURN_CLEAR goes from RM_REMAP to RM_NORMAL on a return.
- T_MOVE_CLEAR goes from RM_REMAP to RM_NORMAL when a move writes 0 to index 17.

A miss in the same cycle beats both clearing transitions. A second enumerated selector picks the source that writes the other bits: SRC_NONE, SRC_MOVE, SRC_SYSCALL or SRC_RETURN.

Top module: `msr_update_unit`

## Requirements
- R1: While reset is low and in the first cycle after it is released, `msr_q` is 0, `pow_en` is 0, `remap_en` is 0 and `rule_viol` is 0.
- R2: A move that is the selected source loads all 32 bits of `mt_data`, including index 17 and index 18, into `msr_q` on the next clock.
- R3: A system-call entry that is the selected source loads `sc_data` into every bit except index 18 (power enable) and index 17 (remap). Those two bits keep their values.
- R4: A return that is the selected source loads `rfe_data` into every bit except index 18, which keeps its value. Index 17 is cleared to 0.
- R5: Any of `imiss_taken`, `dload_miss_taken` or `dstore_miss_taken` makes index 17 (`remap_en`) 1 on the next clock. The other bits follow whatever source is selected.
- R6: When a miss and a return occur in the same cycle, the remap bit ends at 1. The other bits still come from the return.
- R7: Source priority is return, then system call, then move. A source that loses arbitration has no effect.
- R8: `pow_en` (index 18) changes only on a cycle whose selected source is a move.
- R9: `rule_viol` pulses high for one cycle, on the clock after a selected move that changes index 18 together with at least one other bit. The write is still applied. A move that changes only index 18, or leaves index 18 alone, does not raise the flag.
- R10: With no strobe active, `msr_q` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mt_valid | input | 1 | Move-to-register strobe |
| mt_data | input | 32 | Move-to-register write data |
| sc_valid | input | 1 | System-call entry strobe |
| sc_data | input | 32 | Value loaded on system-call entry |
| rfe_valid | input | 1 | Return-from-exception strobe |
| rfe_data | input | 32 | Saved value restored on return |
| imiss_taken | input | 1 | Instruction translation miss taken |
| dload_miss_taken | input | 1 | Data load translation miss taken |
| dstore_miss_taken | input | 1 | Data store translation miss taken |
| msr_q | output | 32 | Current register value (read port) |
| pow_en | output | 1 | Power-mode enable, index 18 |
| remap_en | output | 1 | Register remap mode, index 17 |
| rule_viol | output | 1 | Power-bit write rule violation pulse |

## Verification
The bench targets several cycles in which strobes collide.

- A miss together with a return must leave remap set. A design that let the return win would drop out of remap mode while a miss handler runs.
- A return, a system call and a move all in one cycle must take the return's data and leave the power bit alone. A wrong priority would load the move's data or flip the power enable.
- System-call and return values with every bit set must not reach index 18.
- The violation flag is checked three ways: on a move that flips the power bit together with other bits, on a move that flips only the power bit, and on a move that loses arbitration. A flawed check would flag legal writes, or miss the illegal one.

// File: rtl/msr_pkg.sv
package msr_pkg;

    typedef enum logic [1:0] {
        SRC_NONE    = 2'd0,
        SRC_MOVE    = 2'd1,
        SRC_SYSCALL = 2'd2,
        SRC_RETURN  = 2'd3
    } msr_src_e;

    typedef enum logic {
        RM_NORMAL = 1'b0,
        RM_REMAP  = 1'b1
    } remap_state_e;

    // Convert a most-significant-first bit number into a vector index
    function automatic int unsigned msb_index(input int unsigned width,
                                              input int unsigned num);
        return width - 1 - num;
    endfunction

endpackage

// File: rtl/msr_src_arbiter.sv
module msr_src_arbiter
    import msr_pkg::*;
(
    input  logic     mt_req,
    input  logic     sc_req,
    input  logic     rfe_req,
    output msr_src_e src
);

    always_comb begin
        unique casez ({rfe_req, sc_req, mt_req})
            3'b1??:  src = SRC_RETURN;
            3'b01?:  src = SRC_SYSCALL;
            3'b001:  src = SRC_MOVE;
            default: src = SRC_NONE;
        endcase
    end

endmodule

// File: rtl/msr_body_mux.sv
module msr_body_mux
    import msr_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned POW_IDX = 18,
    parameter int unsigned RMP_IDX = 17
) (
    input  msr_src_e          src,
    input  logic [XLEN-1:0]   cur_body,
    input  logic [XLEN-1:0]   mt_data,
    input  logic [XLEN-1:0]   sc_data,
    input  logic [XLEN-1:0]   rfe_data,
    output logic [XLEN-1:0]   body_next
);

    logic [XLEN-1:0] pick;

    always_comb begin
        pick = cur_body;
        unique case (src)
            SRC_MOVE: begin
                pick = mt_data;
            end
            SRC_SYSCALL: begin
                pick          = sc_data;
                pick[POW_IDX] = cur_body[POW_IDX];
            end
            SRC_RETURN: begin
                pick          = rfe_data;
                pick[POW_IDX] = cur_body[POW_IDX];
            end
            SRC_NONE: begin
                pick = cur_body;
            end
        endcase
        // the remap position is owned by the remap state machine
        body_next          = pick;
        body_next[RMP_IDX] = 1'b0;
    end

endmodule

// File: rtl/msr_move_check.sv
module msr_move_check
    import msr_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned POW_IDX = 18
) (
    input  msr_src_e        src,
    input  logic [XLEN-1:0] cur_msr,
    input  logic [XLEN-1:0] mt_data,
    output logic            viol
);

    localparam logic [XLEN-1:0] POW_MASK = {{(XLEN-1){1'b0}}, 1'b1} << POW_IDX;

    logic [XLEN-1:0] diff;
    logic            pow_flip;
    logic            other_flip;

    always_comb begin
        diff       = cur_msr ^ mt_data;
        pow_flip   = |(diff & POW_MASK);
        other_flip = |(diff & ~POW_MASK);
        viol       = (src == SRC_MOVE) && pow_flip && other_flip;
    end

endmodule

// File: rtl/msr_remap_fsm.sv
module msr_remap_fsm
    import msr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     miss_evt,
    input  msr_src_e src,
    input  logic     mt_bit,
    output logic     remap
);

    remap_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RM_NORMAL;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RM_NORMAL: begin
                if (miss_evt) begin
                    state_d = RM_REMAP;                 // T_MISS_ENTER
                end else if (src == SRC_MOVE && mt_bit) begin
                    state_d = RM_REMAP;                 // T_MOVE_SET
                end
            end
            RM_REMAP: begin
                if (miss_evt) begin
                    state_d = RM_REMAP;
                end else if (src == SRC_RETURN) begin
                    state_d = RM_NORMAL;                // T_RETURN_CLEAR
                end else if (src == SRC_MOVE && !mt_bit) begin
                    state_d = RM_NORMAL;                // T_MOVE_CLEAR
                end
            end
        endcase
    end

    always_comb begin
        remap = (state_q == RM_REMAP);
    end

    // R6
    miss_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_evt && src == SRC_RETURN) |=> (state_q == RM_REMAP));

endmodule

// File: rtl/msr_update_unit.sv
module msr_update_unit
    import msr_pkg::*;
#(
    parameter int unsigned XLEN      = 32,
    parameter int unsigned POW_NUM   = 13,
    parameter int unsigned REMAP_NUM = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mt_valid,
    input  logic [XLEN-1:0] mt_data,
    input  logic            sc_valid,
    input  logic [XLEN-1:0] sc_data,
    input  logic            rfe_valid,
    input  logic [XLEN-1:0] rfe_data,
    input  logic            imiss_taken,
    input  logic            dload_miss_taken,
    input  logic            dstore_miss_taken,
    output logic [XLEN-1:0] msr_q,
    output logic            pow_en,
    output logic            remap_en,
    output logic            rule_viol
);

    localparam int unsigned POW_IDX = msb_index(XLEN, POW_NUM);
    localparam int unsigned RMP_IDX = msb_index(XLEN, REMAP_NUM);
    localparam logic [XLEN-1:0] ONE = {{(XLEN-1){1'b0}}, 1'b1};

    msr_src_e        src;
    logic [XLEN-1:0] body_q, body_d;
    logic            viol_d, viol_q;
    logic            miss_evt;
    logic            remap;

    assign miss_evt = imiss_taken | dload_miss_taken | dstore_miss_taken;

    msr_src_arbiter u_arb (
        .mt_req  (mt_valid),
        .sc_req  (sc_valid),
        .rfe_req (rfe_valid),
        .src     (src)
    );

    msr_body_mux #(
        .XLEN    (XLEN),
        .POW_IDX (POW_IDX),
        .RMP_IDX (RMP_IDX)
    ) u_mux (
        .src       (src),
        .cur_body  (body_q),
        .mt_data   (mt_data),
        .sc_data   (sc_data),
        .rfe_data  (rfe_data),
        .body_next (body_d)
    );

    msr_move_check #(
        .XLEN    (XLEN),
        .POW_IDX (POW_IDX)
    ) u_chk (
        .src     (src),
        .cur_msr (msr_q),
        .mt_data (mt_data),
        .viol    (viol_d)
    );

    msr_remap_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .miss_evt (miss_evt),
        .src      (src),
        .mt_bit   (mt_data[RMP_IDX]),
        .remap    (remap)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            body_q <= '0;
            viol_q <= 1'b0;
        end else begin
            body_q <= body_d;
            viol_q <= viol_d;
        end
    end

    always_comb begin
        msr_q     = body_q | (remap ? (ONE << RMP_IDX) : '0);
        pow_en    = body_q[POW_IDX];
        remap_en  = remap;
        rule_viol = viol_q;
    end

    // R8
    pow_only_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src != SRC_MOVE) |=> $stable(pow_en));

    // R5
    miss_sets_remap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_evt |=> remap_en);

    // R4
    return_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rfe_valid && !miss_evt) |=> !remap_en);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mt_valid && !sc_valid && !rfe_valid && !miss_evt) |=> $stable(msr_q));

    // R9
    viol_after_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rule_viol |-> $past(mt_valid));

    // R7
    src_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rfe_valid |=> (msr_q[POW_IDX] == $past(msr_q[POW_IDX])));

endmodule

// File: tb/test_msr_update_unit.sv
`timescale 1ns/1ps
module test_msr_update_unit;

    localparam int POW = 18;
    localparam int RMP = 17;

    typedef struct {
        logic [31:0] msr;
        logic        viol;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mt_valid = 0, sc_valid = 0, rfe_valid = 0;
    logic [31:0] mt_data = '0, sc_data = '0, rfe_data = '0;
    logic        imiss = 0, dload = 0, dstore = 0;
    logic [31:0] msr_q;
    logic        pow_en, remap_en, rule_viol;

    int compared = 0;
    int mismatched = 0;
    exp_t sb[$];
    logic [31:0] model = '0;

    always #2 clk = ~clk;

    msr_update_unit i_msr_update_unit (
        .clk               (clk),
        .rst_n             (rst_n),
        .mt_valid          (mt_valid),
        .mt_data           (mt_data),
        .sc_valid          (sc_valid),
        .sc_data           (sc_data),
        .rfe_valid         (rfe_valid),
        .rfe_data          (rfe_data),
        .imiss_taken       (imiss),
        .dload_miss_taken  (dload),
        .dstore_miss_taken (dstore),
        .msr_q             (msr_q),
        .pow_en            (pow_en),
        .remap_en          (remap_en),
        .rule_viol         (rule_viol)
    );

    task automatic drive(input logic mt, input logic [31:0] md,
                         input logic sc, input logic [31:0] sd,
                         input logic rf, input logic [31:0] rd,
                         input logic im, input logic dl, input logic ds,
                         input string tag);
        exp_t        e;
        logic [31:0] nxt;
        logic [31:0] diff;
        @(negedge clk);
        mt_valid = mt; mt_data = md;
        sc_valid = sc; sc_data = sd;
        rfe_valid = rf; rfe_data = rd;
        imiss = im; dload = dl; dstore = ds;
        nxt    = model;
        e.viol = 1'b0;
        if (rf) begin
            nxt      = rd;
            nxt[POW] = model[POW];
            nxt[RMP] = 1'b0;
        end else if (sc) begin
            nxt      = sd;
            nxt[POW] = model[POW];
            nxt[RMP] = model[RMP];
        end else if (mt) begin
            nxt  = md;
            diff = md ^ model;
            e.viol = diff[POW] && ((diff & ~(32'h1 << POW)) != 0);
        end
        if (im || dl || ds) nxt[RMP] = 1'b1;
        e.msr = nxt;
        e.tag = tag;
        sb.push_back(e);
        model = nxt;
    endtask

    task automatic idle(input string tag);
        drive(0, '0, 0, '0, 0, '0, 0, 0, 0, tag);
    endtask

    // monitor: compares one expected item per clock after the edge
    always @(posedge clk) begin
        #1;
        if (rst_n && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            compared++;
            if (msr_q !== e.msr || rule_viol !== e.viol ||
                pow_en !== e.msr[POW] || remap_en !== e.msr[RMP]) begin
                mismatched++;
                $display("FAIL %s: msr=%h viol=%b pow=%b remap=%b expected msr=%h viol=%b",
                         e.tag, msr_q, rule_viol, pow_en, remap_en, e.msr, e.viol);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: values held in reset
        compared++;
        if (msr_q !== 32'h0 || pow_en !== 0 || remap_en !== 0 || rule_viol !== 0) begin
            mismatched++;
            $display("FAIL R1: msr=%h pow=%b remap=%b viol=%b expected all zero",
                     msr_q, pow_en, remap_en, rule_viol);
        end
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R1: first cycle after release
        compared++;
        if (msr_q !== 32'h0 || rule_viol !== 0) begin
            mismatched++;
            $display("FAIL R1: msr=%h viol=%b expected 0 0", msr_q, rule_viol);
        end

        // R2 and R9: full load, power bit changes with other bits
        drive(1, 32'hDEAD_BEEF, 0, '0, 0, '0, 0, 0, 0, "R2/R9 move load flagged");
        idle("R10 hold after move");
        // R9: power bit alone flips, no flag
        drive(1, model ^ 32'h0004_0000, 0, '0, 0, '0, 0, 0, 0, "R9 pow-only move");
        // R9: other bits change, power bit untouched, no flag
        drive(1, (model & 32'h0004_0000) | 32'h0000_00F0, 0, '0, 0, '0, 0, 0, 0,
              "R9 move keeps pow");
        // R3 and R8: syscall with all ones keeps pow and remap
        drive(0, '0, 1, 32'hFFFF_FFFF, 0, '0, 0, 0, 0, "R3/R8 syscall");
        // R5: each miss kind sets remap
        drive(0, '0, 0, '0, 0, '0, 1, 0, 0, "R5 instruction miss");
        drive(0, '0, 0, '0, 1, 32'h0000_1111, 0, 0, 0, "R4 return clears remap");
        drive(0, '0, 0, '0, 0, '0, 0, 1, 0, "R5 load miss");
        drive(0, '0, 0, '0, 1, 32'h0000_2222, 0, 0, 0, "R4 return");
        drive(0, '0, 0, '0, 0, '0, 0, 0, 1, "R5 store miss");
        // R6: miss and return together
        drive(0, '0, 0, '0, 1, 32'hFFFF_FFFF, 1, 0, 0, "R6 miss beats return, R4/R8 pow kept");
        // R7: all three sources at once, return wins
        drive(1, 32'h0000_0000, 1, 32'h5555_5555, 1, 32'h0F0F_0F0F, 0, 0, 0,
              "R7 return wins");
        // R7: syscall beats move, losing move cannot flag
        drive(1, 32'hFFFF_FFFF, 1, 32'h3333_0000, 0, '0, 0, 0, 0, "R7 syscall beats move");
        // R2: move sets remap, then clears it
        drive(1, 32'h0002_0001, 0, '0, 0, '0, 0, 0, 0, "R2 move sets remap");
        drive(1, 32'h0000_0001, 0, '0, 0, '0, 0, 0, 0, "R2 move clears remap");
        idle("R10 idle");
        idle("R10 idle again");
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule